// File: doc/BRIEF.md
# Prescaled Count/Compare Timer

This block is a 32-bit system timer built from two registers: a free-running Count and a Compare threshold. Count advances once for every N core clock cycles. N comes from a static divisor input, and a divisor of zero behaves like one. When an increment brings Count to the same value as Compare, the block raises a raw pending line for interrupt 7. That line stays high until software writes Compare again. Masking and prioritisation of this line happen elsewhere.

Software reaches both registers through a simple write port and a read port. A write takes only the low 32 bits of the data word. A read returns the selected 32-bit register sign-extended to the full data width. Writing Count moves the timer to a new position and restarts the prescaler. It leaves an already pending interrupt untouched. Writing Compare moves the threshold and acknowledges the interrupt.

Top module: `tick_match_timer`

## Requirements
- R1: After reset, Count and Compare both read zero and the interrupt line is low.
- R2: With no Count write, Count increases by one every N clock cycles, where N is the divisor input. A divisor of 0 gives N = 1. The first increment after reset comes N cycles after reset is released.
- R3: The interrupt line rises after the clock edge at which an increment makes Count equal to Compare.
- R4: Once set, the interrupt line stays high until a Compare write. A Compare write clears it, unless the same edge also brings an increment that matches the newly written Compare value.
- R5: A Count write (wr_sel_i = 0) loads Count, restarts the prescaler so that the next increment comes N cycles after the write edge, does not clear a pending interrupt and does not itself set one.
- R6: A Compare write (wr_sel_i = 1) loads Compare at the next edge and leaves the prescaler phase unchanged.
- R7: rd_sel_i = 0 selects Count and rd_sel_i = 1 selects Compare. The read data copies bit 31 of the selected register into every bit from 32 upward.
- R8: Count wraps from 0xFFFFFFFF to 0 with no other effect.
- R9: Bits 32 and above of the write data are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| div_cfg_i | input | DIV_W | Static prescale divisor (0 behaves as 1) |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 Count, 1 Compare |
| wr_data_i | input | DATA_W | Write data; only the low 32 bits are used |
| rd_sel_i | input | 1 | Read target: 0 Count, 1 Compare |
| rd_data_o | output | DATA_W | Selected register, sign-extended |
| irq7_o | output | 1 | Raw timer interrupt pending line |

## Verification
The hardest situation to reach is a match that lands on the same edge as another event. Three cases fall under this: a Compare write while an increment is due, a Count write that has to leave a pending interrupt in place, and a wrap through all ones while a threshold sits elsewhere. Free-running stimulus almost never gets there, because the register values are 32 bits wide. The random stimulus therefore places each new Count a few steps below the current Compare, or each new Compare a few steps above the current Count. Matches then happen within a handful of prescaled ticks, under divisors of 0, 1 and 3. Directed sequences cover the wrap and the prescaler restart.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    parameter int TMR_CNT_W = 32;

    typedef enum logic {
        SEL_COUNT = 1'b0,
        SEL_CMP   = 1'b1
    } tmr_sel_e;

    typedef struct packed {
        logic [TMR_CNT_W-1:0] count;
        logic [TMR_CNT_W-1:0] cmp;
        logic                 pend;
    } tmr_core_t;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int DIV_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [DIV_W-1:0] div_cfg_i,
    input  logic             restart_i,
    output logic             tick_o
);
    typedef struct packed {
        logic [DIV_W-1:0] phase;
    } pre_t;

    pre_t             st_d, st_q;
    logic [DIV_W-1:0] last_phase;

    // divisor zero acts as divide-by-one
    always_comb begin
        if (div_cfg_i == '0) begin
            last_phase = '0;
        end else begin
            last_phase = div_cfg_i - 1'b1;
        end
    end

    always_comb begin
        st_d   = st_q;
        tick_o = 1'b0;
        if (restart_i) begin
            st_d.phase = '0;
        end else if (st_q.phase >= last_phase) begin
            tick_o     = 1'b1;
            st_d.phase = '0;
        end else begin
            st_d.phase = st_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = TMR_CNT_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             wr_cnt_i,
    input  logic             wr_cmp_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] cmp_o,
    output logic             pend_o
);
    tmr_core_t        st_d, st_q;
    logic [CNT_W-1:0] count_inc;

    assign count_inc = st_q.count + 1'b1;

    always_comb begin
        st_d = st_q;
        if (wr_cnt_i) begin
            // new position; pending state kept as is
            st_d.count = wdata_i;
        end else if (tick_i) begin
            st_d.count = count_inc;
        end
        if (wr_cmp_i) begin
            st_d.cmp  = wdata_i;
            st_d.pend = 1'b0;
        end
        if (tick_i && !wr_cnt_i && (count_inc == st_d.cmp)) begin
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.count;
    assign cmp_o   = st_q.cmp;
    assign pend_o  = st_q.pend;
endmodule

// File: rtl/tmr_readout.sv
module tmr_readout #(
    parameter int CNT_W  = 32,
    parameter int DATA_W = 64
) (
    input  logic              sel_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic [CNT_W-1:0]  cmp_i,
    output logic [DATA_W-1:0] rd_o
);
    logic [CNT_W-1:0] picked;

    assign picked = sel_i ? cmp_i : count_i;

    generate
        if (DATA_W > CNT_W) begin : g_ext
            assign rd_o = {{(DATA_W-CNT_W){picked[CNT_W-1]}}, picked};
        end else begin : g_trunc
            assign rd_o = picked[DATA_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/tick_match_timer.sv
module tick_match_timer
    import tmr_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int DIV_W  = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [DIV_W-1:0]  div_cfg_i,
    input  logic              wr_en_i,
    input  logic              wr_sel_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_sel_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              irq7_o
);
    localparam int CNT_W = TMR_CNT_W;
    localparam int LOW_W = (DATA_W < CNT_W) ? DATA_W : CNT_W;

    logic             wr_cnt_w;
    logic             wr_cmp_w;
    logic             tick_w;
    logic [CNT_W-1:0] wdata_w;
    logic [CNT_W-1:0] count_w;
    logic [CNT_W-1:0] cmp_w;

    assign wr_cnt_w = wr_en_i && (tmr_sel_e'(wr_sel_i) == SEL_COUNT);
    assign wr_cmp_w = wr_en_i && (tmr_sel_e'(wr_sel_i) == SEL_CMP);

    always_comb begin
        wdata_w            = '0;
        wdata_w[LOW_W-1:0] = wr_data_i[LOW_W-1:0];
    end

    tmr_prescale #(.DIV_W(DIV_W)) u_pre (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .div_cfg_i (div_cfg_i),
        .restart_i (wr_cnt_w),
        .tick_o    (tick_w)
    );

    tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .tick_i   (tick_w),
        .wr_cnt_i (wr_cnt_w),
        .wr_cmp_i (wr_cmp_w),
        .wdata_i  (wdata_w),
        .count_o  (count_w),
        .cmp_o    (cmp_w),
        .pend_o   (irq7_o)
    );

    tmr_readout #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_rd (
        .sel_i   (rd_sel_i),
        .count_i (count_w),
        .cmp_i   (cmp_w),
        .rd_o    (rd_data_o)
    );
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
    parameter int DATA_W = 64,
    parameter int CNT_W  = 32
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              wr_en_i,
    input logic              wr_sel_i,
    input logic [DATA_W-1:0] wr_data_i,
    input logic              rd_sel_i,
    input logic [DATA_W-1:0] rd_data_o,
    input logic              irq7_o,
    input logic              tick,
    input logic [CNT_W-1:0]  count,
    input logic [CNT_W-1:0]  cmp
);
    logic wr_cnt, wr_cmp;
    assign wr_cnt = wr_en_i && !wr_sel_i;
    assign wr_cmp = wr_en_i && wr_sel_i;

    assert_count_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick && !wr_cnt) |=> (count == CNT_W'($past(count) + 1'b1)));

    assert_count_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick && !wr_cnt) |=> $stable(count));

    assert_irq_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq7_o && !wr_cmp) |=> irq7_o);

    assert_irq_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_cmp && !tick) |=> !irq7_o);

    assert_cnt_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_cnt |=> (irq7_o == $past(irq7_o)));

    assert_cmp_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_cmp |=> (cmp == $past(wr_data_i[CNT_W-1:0])));

    assert_rd_ext_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_sel_i |-> (rd_data_o[DATA_W-1:CNT_W] == {(DATA_W-CNT_W){count[CNT_W-1]}}));
endmodule

bind tick_match_timer tmr_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .rd_sel_i  (rd_sel_i),
    .rd_data_o (rd_data_o),
    .irq7_o    (irq7_o),
    .tick      (tick_w),
    .count     (count_w),
    .cmp       (cmp_w)
);

// File: tb/tick_match_timer_tb_top.sv
module tick_match_timer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  div_cfg = '0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [63:0] wr_data = '0;
    logic        rd_sel = 1'b0;
    logic [63:0] rd_data;
    logic        irq7;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done = 1'b0;

    // bench model state
    logic [31:0] m_count, m_cmp;
    logic        m_irq;
    int          m_pre;

    always #(CLK_PERIOD/2) clk = ~clk;

    tick_match_timer dut_i (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .div_cfg_i (div_cfg),
        .wr_en_i   (wr_en),
        .wr_sel_i  (wr_sel),
        .wr_data_i (wr_data),
        .rd_sel_i  (rd_sel),
        .rd_data_o (rd_data),
        .irq7_o    (irq7)
    );

    function automatic logic [63:0] sext(input logic [31:0] v);
        return {{32{v[31]}}, v};
    endfunction

    function automatic int eff_div(input logic [7:0] d);
        return (d == 0) ? 1 : int'(d);
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // one clock: drive at negedge, advance model, compare after the edge
    task automatic step(input logic we, input logic sel, input logic [63:0] d, input logic rs);
        logic tick;
        wr_en = we; wr_sel = sel; wr_data = d; rd_sel = rs;
        tick = 1'b0;
        if (we && !sel) begin
            m_count = d[31:0];
            m_pre = 0;
        end else begin
            tick = (m_pre >= eff_div(div_cfg) - 1);
            m_pre = tick ? 0 : m_pre + 1;
            if (tick) m_count = m_count + 32'd1;
        end
        if (we && sel) begin
            m_cmp = d[31:0];
            m_irq = 1'b0;
        end
        if (tick && (m_count == m_cmp)) m_irq = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        chk("R7 read", rd_data, sext(rs ? m_cmp : m_count));
        chk("R3/R4 irq", {63'd0, irq7}, {63'd0, m_irq});
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 64'd0, 1'b0);
    endtask

    task automatic do_reset(input logic [7:0] d);
        rst_n = 1'b0;
        wr_en = 1'b0;
        div_cfg = d;
        m_count = '0; m_cmp = '0; m_irq = 1'b0; m_pre = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd_sel = 1'b0;
        #1;
        chk("R1 count", rd_data, 64'd0);
        rd_sel = 1'b1;
        #1;
        chk("R1 compare", rd_data, 64'd0);
        chk("R1 irq", {63'd0, irq7}, 64'd0);
    endtask

    task automatic random_run(input int n);
        for (int i = 0; i < n; i++) begin
            int r;
            r = int'($urandom % 100);
            if (r < 8)
                step(1'b1, 1'b0, {$urandom, m_cmp - ($urandom % 6)}, 1'($urandom));
            else if (r < 16)
                step(1'b1, 1'b1, {$urandom, m_count + ($urandom % 6)}, 1'($urandom));
            else if (r < 18)
                step(1'b1, 1'($urandom), {$urandom, $urandom}, 1'($urandom));
            else
                step(1'b0, 1'b0, 64'd0, 1'($urandom));
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
                summary();
            end
        end
    end

    initial begin
        void'($urandom(32'h5eed_0007));

        // divisor 1
        do_reset(8'd1);
        step(1'b1, 1'b0, 64'hDEAD_BEEF_0000_0005, 1'b0);
        chk("R9 upper bits dropped", rd_data, 64'd5);
        step(1'b1, 1'b0, 64'h0000_0000_8000_0000, 1'b0);
        chk("R7 sign extension", rd_data, 64'hFFFF_FFFF_8000_0000);
        step(1'b1, 1'b1, 64'h0000_0001_8000_0001, 1'b1);
        chk("R6 compare load", rd_data, 64'hFFFF_FFFF_8000_0001);
        step(1'b1, 1'b1, 64'd100, 1'b0);
        step(1'b1, 1'b0, 64'd97, 1'b0);
        idle(2);
        chk("R3 no irq before match", {63'd0, irq7}, 64'd0);
        idle(1);
        chk("R3 irq on match", {63'd0, irq7}, 64'd1);
        idle(5);
        chk("R4 irq held", {63'd0, irq7}, 64'd1);
        step(1'b1, 1'b0, 64'd50, 1'b0);
        chk("R5 count write keeps irq", {63'd0, irq7}, 64'd1);
        step(1'b1, 1'b1, 64'd1000, 1'b0);
        chk("R4 compare write clears irq", {63'd0, irq7}, 64'd0);
        step(1'b1, 1'b1, 64'd5, 1'b0);
        step(1'b1, 1'b0, 64'hFFFF_FFFF, 1'b0);
        idle(1);
        chk("R8 wrap count", rd_data, 64'd0);
        chk("R8 wrap no irq", {63'd0, irq7}, 64'd0);
        random_run(3000);

        // divisor 0 acts as 1
        do_reset(8'd0);
        step(1'b1, 1'b0, 64'd10, 1'b0);
        idle(2);
        chk("R2 divisor zero", rd_data, 64'd12);
        random_run(3000);

        // divisor 3
        do_reset(8'd3);
        idle(2);
        chk("R2 first tick pending", rd_data, 64'd0);
        idle(1);
        chk("R2 first tick after reset", rd_data, 64'd1);
        step(1'b1, 1'b0, 64'd10, 1'b0);
        idle(2);
        chk("R2 no tick yet", rd_data, 64'd10);
        idle(1);
        chk("R2 tick after three", rd_data, 64'd11);
        idle(1);
        step(1'b1, 1'b0, 64'd20, 1'b0);
        idle(2);
        chk("R5 prescaler restart", rd_data, 64'd20);
        idle(1);
        chk("R5 increment after restart", rd_data, 64'd21);
        random_run(4000);

        summary();
    end
endmodule